// File: doc/BRIEF.md
# Vector Address Generation Unit

This unit forms a whole vector of memory addresses in a single operation. It takes a 32-bit instruction word, a valid strobe and two source vectors: one holds base addresses and the other holds offsets. Each lane of the result is the base plus the offset shifted left by 0 to 3 places. The shift scales the offset by the size of the element that will later be accessed. The vector width is a parameter that must be a multiple of 64 bits. Every lane is computed; there is no lane masking.

A 2-bit variant field picks one of four lane layouts:
- packed 64-bit lanes;
- packed 32-bit lanes;
- 64-bit lanes whose offset is taken from its low 32 bits and sign-extended;
- 64-bit lanes whose offset is taken from its low 32 bits and zero-extended.

Words whose fixed opcode bits do not match are flagged as illegal and return a zero result. The result, the destination register index and the flags appear one clock after the valid input.

Top module: `vec_addr_gen`

## Requirements
- R1: A word is accepted only when insn[31:24] is 8'h04, insn[21] is 1 and insn[15:12] is 4'b1010. A valid word that fails any of these checks raises out_illegal and leaves out_valid low in the next cycle.
- R2: Variant insn[23:22]=2'b11 computes each 64-bit lane as base + (offset << shift). The shifted offset and the sum both wrap modulo 2^64.
- R3: Variant 2'b10 computes each 32-bit lane on its own as base + (offset << shift) modulo 2^32. No carry and no shifted-out bit crosses into the next lane.
- R4: Variant 2'b00 sign-extends bits [31:0] of each 64-bit offset lane to 64 bits before the shift. Bits [63:32] of the offset have no effect.
- R5: Variant 2'b01 zero-extends bits [31:0] of each 64-bit offset lane to 64 bits before the shift.
- R6: The shift amount is insn[11:10], giving a left shift of 0, 1, 2 or 3.
- R7: Every lane across the full vector width is computed; no lane is masked.
- R8: The result, rd_idx (taken from insn[4:0]) and out_valid are registered one clock after a valid legal input.
- R9: For an illegal word the registered result is all zero.
- R10: A synchronous active-high reset clears out_valid and out_illegal. A cycle with in_valid low leaves both flags low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operands are present |
| insn | input | 32 | Instruction word |
| base_vec | input | VLEN | Base address vector |
| ofs_vec | input | VLEN | Offset vector |
| res_vec | output | VLEN | Computed address vector |
| rd_idx | output | 5 | Destination register index |
| out_valid | output | 1 | Registered result is valid |
| out_illegal | output | 1 | Registered word failed opcode match |

## Verification
The assertions compare outputs with the inputs seen one cycle earlier. They therefore assume that insn and both operand vectors carry known values in every cycle where in_valid is high, and that the inputs are defined during reset so that the first sample after reset is meaningful. The stimulus meets these assumptions. Every input is driven to a defined value from time zero, and inputs change only on the falling edge. Operands are held at defined values while in_valid is low. Illegal words are built by flipping exactly one fixed opcode bit of a legal word, so each decode check is exercised on its own.

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic [VLEN-1:0] base_vec,
  input  logic [VLEN-1:0] ofs_vec,
  output logic [VLEN-1:0] res_vec,
  output logic [4:0]      rd_idx,
  output logic            out_valid,
  output logic            out_illegal
);
  localparam int NLANE = VLEN / 64;

  logic            match;
  logic [1:0]      kind;
  logic [1:0]      sh;
  logic [VLEN-1:0] sum;

  assign match = (insn[31:24] == 8'h04) && insn[21] && (insn[15:12] == 4'b1010);
  assign kind  = insn[23:22];
  assign sh    = insn[11:10];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [63:0] b, o, ext;
    logic [31:0] lo, hi;
    assign b   = base_vec[g*64 +: 64];
    assign o   = ofs_vec[g*64 +: 64];
    assign ext = (kind == 2'b00) ? {{32{o[31]}}, o[31:0]} :
                 (kind == 2'b01) ? {32'b0, o[31:0]} : o;
    assign lo  = b[31:0]  + (o[31:0]  << sh);
    assign hi  = b[63:32] + (o[63:32] << sh);
    assign sum[g*64 +: 64] = (kind == 2'b10) ? {hi, lo} : b + (ext << sh);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      res_vec     <= '0;
      rd_idx      <= '0;
    end else begin
      out_valid   <= in_valid & match;
      out_illegal <= in_valid & ~match;
      if (in_valid) begin
        rd_idx  <= insn[4:0];
        res_vec <= match ? sum : '0;
      end
    end
  end
endmodule

// File: rtl/vec_addr_gen_chk.sv
module vec_addr_gen_chk #(
  parameter int VLEN = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [31:0]     insn,
  input logic [VLEN-1:0] base_vec,
  input logic [VLEN-1:0] ofs_vec,
  input logic [VLEN-1:0] res_vec,
  input logic [4:0]      rd_idx,
  input logic            out_valid,
  input logic            out_illegal
);
  logic        legal;
  logic [63:0] p64_exp;
  logic [31:0] hi32_exp;

  assign legal    = insn[31:24] == 8'b0000_0100 && insn[21] == 1'b1 && insn[15:12] == 4'hA;
  assign p64_exp  = base_vec[63:0] + (ofs_vec[63:0] << insn[11:10]);
  assign hi32_exp = base_vec[63:32] + (ofs_vec[63:32] << insn[11:10]);

  AST_DECODE_REJECT: assert property (@(posedge clk) disable iff (rst)
    in_valid && !legal |=> out_illegal && !out_valid); // R1
  AST_P64_LANE0: assert property (@(posedge clk) disable iff (rst)
    in_valid && legal && insn[23:22] == 2'b11 |=> res_vec[63:0] == $past(p64_exp)); // R2
  AST_P32_UPPER_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    in_valid && legal && insn[23:22] == 2'b10 |=> res_vec[63:32] == $past(hi32_exp)); // R3
  AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid && legal |=> out_valid); // R8
  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> rd_idx == $past(insn[4:0])); // R8
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> res_vec == '0); // R9
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_illegal)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !out_illegal); // R10
endmodule

bind vec_addr_gen vec_addr_gen_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
  .base_vec(base_vec), .ofs_vec(ofs_vec), .res_vec(res_vec),
  .rd_idx(rd_idx), .out_valid(out_valid), .out_illegal(out_illegal)
);

// File: tb/test_vec_addr_gen.sv
module test_vec_addr_gen;
  localparam int VL = 128;
  localparam int NL = VL / 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [31:0]   insn = '0;
  logic [VL-1:0] base_vec = '0;
  logic [VL-1:0] ofs_vec = '0;
  logic [VL-1:0] res_vec;
  logic [4:0]    rd_idx;
  logic          out_valid, out_illegal;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_addr_gen #(.VLEN(VL)) i_vec_addr_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .base_vec(base_vec), .ofs_vec(ofs_vec), .res_vec(res_vec),
    .rd_idx(rd_idx), .out_valid(out_valid), .out_illegal(out_illegal)
  );

  function automatic logic [31:0] mk(input logic [1:0] k, input logic [1:0] s,
                                     input logic [4:0] rm, input logic [4:0] rn, input logic [4:0] rd);
    return {8'h04, k, 1'b1, rm, 4'b1010, s, rn, rd};
  endfunction

  function automatic logic [VL-1:0] model(input logic [1:0] k, input logic [1:0] s,
                                          input logic [VL-1:0] b, input logic [VL-1:0] o);
    logic [VL-1:0] r;
    logic [63:0] mul;
    mul = 64'd1 << s;
    r = '0;
    for (int i = 0; i < NL; i++) begin
      logic [63:0] bb, oo, e;
      logic [31:0] l, h;
      bb = b[i*64 +: 64];
      oo = o[i*64 +: 64];
      if (k == 2'b10) begin
        l = bb[31:0]  + oo[31:0]  * mul[31:0];
        h = bb[63:32] + oo[63:32] * mul[31:0];
        r[i*64 +: 64] = {h, l};
      end else begin
        if (k == 2'b00)      e = {{32{oo[31]}}, oo[31:0]};
        else if (k == 2'b01) e = {32'b0, oo[31:0]};
        else                 e = oo;
        r[i*64 +: 64] = bb + e * mul;
      end
    end
    return r;
  endfunction

  function automatic logic [VL-1:0] rnd();
    logic [VL-1:0] v;
    for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run(input logic [31:0] w, input logic [VL-1:0] b, input logic [VL-1:0] o, input string tag);
    logic legal;
    logic [VL-1:0] exp_res;
    @(negedge clk);
    insn = w; base_vec = b; ofs_vec = o; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    legal = (w[31:24] == 8'h04) && w[21] && (w[15:12] == 4'hA);
    exp_res = legal ? model(w[23:22], w[11:10], b, o) : '0;
    vectors++;
    if (res_vec !== exp_res || rd_idx !== w[4:0] || out_valid !== legal || out_illegal !== !legal) begin
      fails++;
      $display("FAIL %s R8: insn=%h res=%h exp=%h rd=%0d/%0d valid=%b/%b illegal=%b/%b",
               tag, w, res_vec, exp_res, rd_idx, w[4:0], out_valid, legal, out_illegal, !legal);
    end
  endtask

  task automatic check_flags(input string tag);
    vectors++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0) begin
      fails++;
      $display("FAIL %s: valid=%b illegal=%b expected 0/0", tag, out_valid, out_illegal);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    string ktag[4];
    logic [31:0] good;
    ktag[0] = "R4"; ktag[1] = "R5"; ktag[2] = "R3"; ktag[3] = "R2";

    repeat (3) @(negedge clk);
    check_flags("R10 reset");
    rst = 1'b0;

    run(mk(2'b11, 2'd0, 5'd1, 5'd2, 5'd3), {NL{64'hFFFF_FFFF_FFFF_FFFF}}, {NL{64'd1}}, "R2 wrap64");
    run(mk(2'b11, 2'd3, 5'd1, 5'd2, 5'd4), '0, {NL{64'hF000_0000_0000_0001}}, "R2 shift-out");
    run(mk(2'b10, 2'd0, 5'd5, 5'd6, 5'd7), {NL{64'hFFFF_FFFF_FFFF_FFFF}}, {NL{64'h0000_0001_0000_0001}}, "R3 no carry");
    run(mk(2'b10, 2'd2, 5'd5, 5'd6, 5'd8), '0, {NL{64'hC000_0001_C000_0001}}, "R3 shift-out");
    run(mk(2'b00, 2'd3, 5'd9, 5'd10, 5'd11), '0, {NL{64'hDEAD_BEEF_8000_0000}}, "R4 sign");
    run(mk(2'b00, 2'd1, 5'd9, 5'd10, 5'd12), {NL{64'd100}}, {NL{64'h1234_5678_0000_0010}}, "R4 upper ignored");
    run(mk(2'b01, 2'd3, 5'd13, 5'd14, 5'd15), '0, {NL{64'hDEAD_BEEF_8000_0000}}, "R5 zero");
    run(mk(2'b11, 2'd1, 5'd0, 5'd0, 5'd31), {64'd7, 64'd5}, {64'd3, 64'd2}, "R7 distinct lanes");

    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 4; s++)
        for (int n = 0; n < 8; n++)
          run(mk(k[1:0], s[1:0], 5'($urandom), 5'($urandom), 5'($urandom)), rnd(), rnd(),
              {ktag[k], " R6 R7 sweep"});

    good = mk(2'b11, 2'd2, 5'd3, 5'd4, 5'd21);
    for (int bit_i = 0; bit_i < 32; bit_i++) begin
      if (bit_i >= 24 || bit_i == 21 || (bit_i >= 12 && bit_i <= 15))
        run(good ^ (32'd1 << bit_i), rnd(), rnd(), "R1 R9 bad opcode");
    end

    @(negedge clk);
    check_flags("R10 idle");

    @(negedge clk);
    insn = good; base_vec = rnd(); ofs_vec = rnd(); in_valid = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_flags("R10 reset after valid");
    rst = 1'b0;
    run(good, rnd(), rnd(), "R2 after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule